// File: doc/BRIEF.md
# Branch Compare and Target Unit

This block decides control flow for a small 16-bit machine with four general registers. Each cycle it can accept one instruction word, together with the current program counter and the contents of all four registers. One cycle later it reports two things: whether the instruction transfers control, and the address of the next instruction to fetch.

It handles three control-transfer forms. The first is a compare-and-jump. It tests a destination register against a source register under one of eight conditions, and on success it jumps to the address held in a third register. The second is a PC-relative jump that carries a 12-bit signed displacement. The third is a jump through a register. Any other instruction word falls through to the next sequential address. Fetch, memory, calls and returns belong to neighbouring blocks.

The result is registered, so the fetch stage sees a clean, glitch-free next-PC value on the cycle after it presents an instruction.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid_o`, `res_taken_o` and `res_next_pc_o` are all cleared to zero.
- R2: `res_valid_o` is high in the cycle after `in_valid_i` was high, and low in the cycle after `in_valid_i` was low.
- R3: For a compare-jump (opcode field [3:0] = 8), condition field [12:10] = 000 means the destination and source are equal, and 001 means they differ. The destination register index is [5:4], the source index is [7:6], and the address register index is [9:8].
- R4: Conditions 010 (less), 011 (greater), 100 (less or equal) and 101 (greater or equal) compare the destination against the source as two's-complement signed 16-bit values.
- R5: Conditions 110 (zero) and 111 (not zero) test only the destination register, and the value of the source register has no effect on the outcome.
- R6: When a compare-jump condition holds, `res_taken_o` is 1 and `res_next_pc_o` equals the address register's value.
- R7: When a compare-jump condition fails, or the opcode is not 8, 11 or 12, `res_taken_o` is 0 and `res_next_pc_o` is PC+1 modulo 2^16.
- R8: A relative jump (opcode 11) is always taken. Its target is PC+1 plus the sign-extended 12-bit offset in bits [15:4], wrapped modulo 2^16.
- R9: A register-indirect jump (opcode 12) is always taken. Its target is the value of the register selected by bits [7:6].
- R10: In a cycle after `in_valid_i` was low, `res_taken_o` and `res_next_pc_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction, PC and registers are valid this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Address of the instruction, in words |
| regs_i | input | 64 | Register values, register n in bits [16n+15:16n] |
| res_valid_o | output | 1 | Result of the previous cycle's instruction is present |
| res_taken_o | output | 1 | Control transfer taken |
| res_next_pc_o | output | 16 | Address of the next instruction |

## Verification
Every decision reaches a port one clock after its inputs. A wrong condition decode, a wrong register selection or a wrong comparison sign therefore appears as a wrong taken bit or a wrong next-PC on that very next cycle. The errors that stay hidden longest sit at the edges of the value ranges: signed-versus-unsigned compares only differ when an operand has bit 15 set, and a wrong sign extension or missing wrap only shows with large offsets or a PC near 0xFFFF. For that reason the stimulus places directed cases at those boundaries. The hold behaviour when no instruction is presented is only visible if the inputs change while `in_valid_i` is low, so the bench does exactly that.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_LT  = 3'b010,
    CND_GT  = 3'b011,
    CND_LE  = 3'b100,
    CND_GE  = 3'b101,
    CND_ZR  = 3'b110,
    CND_NZ  = 3'b111
  } cond_e;

  localparam int unsigned CONDW      = 3;
  localparam int unsigned OPW        = 4;
  localparam logic [3:0]  OPC_CMPJ   = 4'd8;
  localparam logic [3:0]  OPC_RELJ   = 4'd11;
  localparam logic [3:0]  OPC_INDJ   = 4'd12;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int unsigned XLEN       = 16,
  parameter bit          SIGNED_CMP = 1'b1
) (
  input  cond_e            cond_i,
  input  logic [XLEN-1:0]  lhs_i,
  input  logic [XLEN-1:0]  rhs_i,
  output logic             hit_o
);

  logic lt_w;
  logic gt_w;
  logic eq_w;
  logic zr_w;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign lt_w = $signed(lhs_i) < $signed(rhs_i);
      assign gt_w = $signed(lhs_i) > $signed(rhs_i);
    end else begin : g_unsigned
      assign lt_w = lhs_i < rhs_i;
      assign gt_w = lhs_i > rhs_i;
    end
  endgenerate

  assign eq_w = (lhs_i == rhs_i);
  assign zr_w = (lhs_i == '0);

  always_comb begin
    unique case (cond_i)
      CND_EQ:  hit_o = eq_w;
      CND_NE:  hit_o = !eq_w;
      CND_LT:  hit_o = lt_w;
      CND_GT:  hit_o = gt_w;
      CND_LE:  hit_o = lt_w || eq_w;
      CND_GE:  hit_o = gt_w || eq_w;
      CND_ZR:  hit_o = zr_w;
      CND_NZ:  hit_o = !zr_w;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int unsigned XLEN       = 16,
  parameter int unsigned NREG       = 4,
  parameter logic [3:0]  OP_CMPJ    = OPC_CMPJ,
  parameter logic [3:0]  OP_RELJ    = OPC_RELJ,
  parameter logic [3:0]  OP_INDJ    = OPC_INDJ,
  parameter bit          SIGNED_CMP = 1'b1
) (
  input  logic [XLEN-1:0]       instr_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic [NREG*XLEN-1:0]  regs_i,
  output logic                  taken_o,
  output logic [XLEN-1:0]       next_pc_o
);

  localparam int unsigned RIW     = $clog2(NREG);
  localparam int unsigned DST_LSB = OPW;
  localparam int unsigned SRC_LSB = OPW + RIW;
  localparam int unsigned ADR_LSB = OPW + 2*RIW;
  localparam int unsigned CND_LSB = OPW + 3*RIW;
  localparam int unsigned OFFW    = XLEN - OPW;

  logic [XLEN-1:0] rf [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_unpack
      assign rf[g] = regs_i[g*XLEN +: XLEN];
    end
  endgenerate

  logic [OPW-1:0]  opc;
  logic [RIW-1:0]  dst_idx;
  logic [RIW-1:0]  src_idx;
  logic [RIW-1:0]  adr_idx;
  cond_e           cond;
  logic [OFFW-1:0] off;
  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] seq_pc;
  logic            cmp_hit;

  assign opc     = instr_i[OPW-1:0];
  assign dst_idx = instr_i[DST_LSB +: RIW];
  assign src_idx = instr_i[SRC_LSB +: RIW];
  assign adr_idx = instr_i[ADR_LSB +: RIW];
  assign cond    = cond_e'(instr_i[CND_LSB +: CONDW]);
  assign off     = instr_i[XLEN-1:OPW];
  assign off_ext = {{OPW{off[OFFW-1]}}, off};
  assign seq_pc  = pc_i + XLEN'(1);

  br_cond_eval #(
    .XLEN       (XLEN),
    .SIGNED_CMP (SIGNED_CMP)
  ) i_cond (
    .cond_i (cond),
    .lhs_i  (rf[dst_idx]),
    .rhs_i  (rf[src_idx]),
    .hit_o  (cmp_hit)
  );

  always_comb begin
    taken_o   = 1'b0;
    next_pc_o = seq_pc;
    if (opc == OP_CMPJ) begin
      if (cmp_hit) begin
        taken_o   = 1'b1;
        next_pc_o = rf[adr_idx];
      end
    end else if (opc == OP_RELJ) begin
      taken_o   = 1'b1;
      next_pc_o = seq_pc + off_ext;
    end else if (opc == OP_INDJ) begin
      taken_o   = 1'b1;
      next_pc_o = rf[src_idx];
    end
  end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
#(
  parameter int unsigned XLEN       = 16,
  parameter int unsigned NREG       = 4,
  parameter logic [3:0]  OP_CMPJ    = OPC_CMPJ,
  parameter logic [3:0]  OP_RELJ    = OPC_RELJ,
  parameter logic [3:0]  OP_INDJ    = OPC_INDJ,
  parameter bit          SIGNED_CMP = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid_i,
  input  logic [XLEN-1:0]       instr_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic [NREG*XLEN-1:0]  regs_i,
  output logic                  res_valid_o,
  output logic                  res_taken_o,
  output logic [XLEN-1:0]       res_next_pc_o
);

  logic            taken_c;
  logic [XLEN-1:0] next_pc_c;

  br_target_gen #(
    .XLEN       (XLEN),
    .NREG       (NREG),
    .OP_CMPJ    (OP_CMPJ),
    .OP_RELJ    (OP_RELJ),
    .OP_INDJ    (OP_INDJ),
    .SIGNED_CMP (SIGNED_CMP)
  ) i_target (
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .regs_i    (regs_i),
    .taken_o   (taken_c),
    .next_pc_o (next_pc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o   <= 1'b0;
      res_taken_o   <= 1'b0;
      res_next_pc_o <= '0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_taken_o   <= taken_c;
        res_next_pc_o <= next_pc_c;
      end
    end
  end

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int unsigned XLEN = 16,
  parameter int unsigned NREG = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid_i,
  input logic [XLEN-1:0]       instr_i,
  input logic [XLEN-1:0]       pc_i,
  input logic [NREG*XLEN-1:0]  regs_i,
  input logic                  res_valid_o,
  input logic                  res_taken_o,
  input logic [XLEN-1:0]       res_next_pc_o
);

  function automatic logic [XLEN-1:0] pick(input logic [NREG*XLEN-1:0] r, input logic [1:0] k);
    return r[k*XLEN +: XLEN];
  endfunction

  logic is_cmp, is_rel, is_ind, is_other;
  assign is_cmp   = in_valid_i && instr_i[3:0] == 4'd8;
  assign is_rel   = in_valid_i && instr_i[3:0] == 4'd11;
  assign is_ind   = in_valid_i && instr_i[3:0] == 4'd12;
  assign is_other = in_valid_i && !(instr_i[3:0] inside {4'd8, 4'd11, 4'd12});

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> res_valid_o);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !res_valid_o);

  assert_zero_test_R5: assert property (@(posedge clk) disable iff (rst)
    (is_cmp && instr_i[12:10] == 3'b110) |=> res_taken_o == ($past(pick(regs_i, instr_i[5:4])) == '0));

  assert_cmp_target_R6: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> res_next_pc_o == (res_taken_o ? $past(pick(regs_i, instr_i[9:8])) : $past(pc_i) + XLEN'(1)));

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
    is_other |=> (!res_taken_o && res_next_pc_o == $past(pc_i) + XLEN'(1)));

  assert_rel_taken_R8: assert property (@(posedge clk) disable iff (rst)
    is_rel |=> res_taken_o);

  assert_ind_target_R9: assert property (@(posedge clk) disable iff (rst)
    is_ind |=> (res_taken_o && res_next_pc_o == $past(pick(regs_i, instr_i[7:6]))));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> ($stable(res_next_pc_o) && $stable(res_taken_o)));

endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN), .NREG(NREG)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid_i    (in_valid_i),
  .instr_i       (instr_i),
  .pc_i          (pc_i),
  .regs_i        (regs_i),
  .res_valid_o   (res_valid_o),
  .res_taken_o   (res_taken_o),
  .res_next_pc_o (res_next_pc_o)
);

// File: tb/test_branch_resolve.sv
module test_branch_resolve;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid_i;
  logic [15:0] instr_i;
  logic [15:0] pc_i;
  logic [63:0] regs_i;
  logic        res_valid_o;
  logic        res_taken_o;
  logic [15:0] res_next_pc_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_resolve i_branch_resolve (
    .clk           (clk),
    .rst           (rst),
    .in_valid_i    (in_valid_i),
    .instr_i       (instr_i),
    .pc_i          (pc_i),
    .regs_i        (regs_i),
    .res_valid_o   (res_valid_o),
    .res_taken_o   (res_taken_o),
    .res_next_pc_o (res_next_pc_o)
  );

  function automatic logic [15:0] rsel(input logic [63:0] r, input logic [1:0] k);
    return r[k*16 +: 16];
  endfunction

  function automatic logic [16:0] model(input logic [15:0] ins, input logic [15:0] pc,
                                        input logic [63:0] r);
    logic signed [15:0] a, b;
    logic hit;
    a = rsel(r, ins[5:4]);
    b = rsel(r, ins[7:6]);
    case (ins[3:0])
      4'd8: begin
        case (ins[12:10])
          3'd0: hit = (a == b);
          3'd1: hit = (a != b);
          3'd2: hit = (a < b);
          3'd3: hit = (a > b);
          3'd4: hit = (a <= b);
          3'd5: hit = (a >= b);
          3'd6: hit = (a == 0);
          default: hit = (a != 0);
        endcase
        return hit ? {1'b1, rsel(r, ins[9:8])} : {1'b0, pc + 16'd1};
      end
      4'd11: return {1'b1, pc + 16'd1 + {{4{ins[15]}}, ins[15:4]}};
      4'd12: return {1'b1, rsel(r, ins[7:6])};
      default: return {1'b0, pc + 16'd1};
    endcase
  endfunction

  function automatic logic [15:0] mk_cmp(input logic [2:0] c, input logic [1:0] ad,
                                         input logic [1:0] s, input logic [1:0] d);
    return {3'b000, c, ad, s, d, 4'd8};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] ins, input logic [15:0] pc,
                       input logic [63:0] r);
    logic [16:0] e;
    @(negedge clk);
    in_valid_i = 1'b1;
    instr_i    = ins;
    pc_i       = pc;
    regs_i     = r;
    e = model(ins, pc, r);
    @(negedge clk);
    check({req, " valid R2"}, {31'd0, res_valid_o}, 32'd1);
    check({req, " taken"}, {31'd0, res_taken_o}, {31'd0, e[16]});
    check({req, " next_pc"}, {16'd0, res_next_pc_o}, {16'd0, e[15:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic        hold_t;
    logic [15:0] hold_pc;
    void'($urandom(32'd20240607));
    rst = 1'b1;
    in_valid_i = 1'b0;
    instr_i = '0;
    pc_i = '0;
    regs_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, res_valid_o}, 32'd0);
    check("R1 taken", {31'd0, res_taken_o}, 32'd0);
    check("R1 next_pc", {16'd0, res_next_pc_o}, 32'd0);
    rst = 1'b0;

    // R3 equal / not equal, R6 target from address register
    apply("R3 eq hit R6", mk_cmp(3'd0, 2'd3, 2'd1, 2'd0), 16'h0100,
          {16'hBEEF, 16'h1234, 16'h1234, 16'h1234});
    apply("R3 ne miss R7", mk_cmp(3'd1, 2'd3, 2'd1, 2'd0), 16'h0100,
          {16'hBEEF, 16'h1234, 16'h1234, 16'h1234});
    // R4 signed boundary: 0x8000 < 0x7FFF when signed
    apply("R4 lt signed", mk_cmp(3'd2, 2'd2, 2'd1, 2'd0), 16'h0020,
          {16'h0000, 16'h4444, 16'h7FFF, 16'h8000});
    apply("R4 gt signed", mk_cmp(3'd3, 2'd2, 2'd1, 2'd0), 16'h0020,
          {16'h0000, 16'h4444, 16'h7FFF, 16'h8000});
    apply("R4 le equal", mk_cmp(3'd4, 2'd2, 2'd1, 2'd0), 16'h0021,
          {16'h0000, 16'h5555, 16'hFFFF, 16'hFFFF});
    apply("R4 ge neg", mk_cmp(3'd5, 2'd2, 2'd1, 2'd0), 16'h0022,
          {16'h0000, 16'h5555, 16'h0001, 16'hFFFF});
    // R5 zero / not zero ignore the source register
    apply("R5 zero src nonzero", mk_cmp(3'd6, 2'd2, 2'd1, 2'd0), 16'h0030,
          {16'h0000, 16'h0777, 16'hFFFF, 16'h0000});
    apply("R5 nz src zero", mk_cmp(3'd7, 2'd2, 2'd1, 2'd0), 16'h0030,
          {16'h0000, 16'h0777, 16'h0000, 16'h0000});
    // R8 relative, wrap and extreme offsets
    apply("R8 wrap up", {12'h005, 4'd11}, 16'hFFFF, 64'h0);
    apply("R8 min offset", {12'h800, 4'd11}, 16'h0010, 64'h0);
    apply("R8 max offset", {12'h7FF, 4'd11}, 16'hF900, 64'h0);
    // R9 register indirect
    apply("R9 indirect", {8'h00, 2'd2, 2'd0, 4'd12}, 16'h0040,
          {16'h1111, 16'hCAFE, 16'h3333, 16'h4444});
    // R7 other opcode falls through, with wrap
    apply("R7 other op", 16'hFFF5, 16'hFFFF, {4{16'hAAAA}});

    // R10 hold while idle: change inputs to a taken jump
    apply("R10 setup", {8'h00, 2'd1, 2'd0, 4'd12}, 16'h0050,
          {16'h0, 16'h0, 16'h2468, 16'h0});
    hold_t  = res_taken_o;
    hold_pc = res_next_pc_o;
    @(negedge clk);
    in_valid_i = 1'b0;
    instr_i = {12'h123, 4'd11};
    pc_i = 16'h7777;
    regs_i = {4{16'h9999}};
    @(negedge clk);
    check("R10 valid low R2", {31'd0, res_valid_o}, 32'd0);
    check("R10 taken hold", {31'd0, res_taken_o}, {31'd0, hold_t});
    check("R10 next hold", {16'd0, res_next_pc_o}, {16'd0, hold_pc});

    // random mix: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins;
      logic [63:0] r;
      int sel;
      sel = $urandom_range(0, 9);
      ins = 16'($urandom);
      if (sel < 6) ins[3:0] = 4'd8;
      else if (sel == 6) ins[3:0] = 4'd11;
      else if (sel == 7) ins[3:0] = 4'd12;
      r = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) r[ins[7:6]*16 +: 16] = r[ins[5:4]*16 +: 16];
      if ($urandom_range(0, 5) == 0) r[ins[5:4]*16 +: 16] = 16'h0000;
      apply("R3-mix random", ins, 16'($urandom), r);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule